// File: doc/BRIEF.md
# Shared Hardware Semaphore Bank

This block is a bank of binary semaphores that several bus masters use for mutual exclusion. Each semaphore sits behind its own 32-bit register. A read of that register is an atomic test-and-set. It returns 0 when the semaphore was free and claims it in the same access. It returns 1 when another requester already holds it. The holder frees the semaphore by writing zero to the same register. A requester that gets 1 should back off for about 50 ns (five cycles at 100 MHz) before it reads again.

A read-only status word reports the size of the bank. The size is a one-hot multiplier of 32 in a four-bit field, so software can discover 32, 64, 128 or 256 semaphores. The bank has a front end with several ports, one for each master. Each port carries address, read strobe, write strobe, write data and read data. When ports race for the same free semaphore in one cycle, the port with the lowest number wins.

Each semaphore is a two-state machine:
- States: `LK_FREE` and `LK_HELD`.
- Transition ACQUIRE (`LK_FREE` to `LK_HELD`): any port reads the semaphore.
- Transition RELEASE (`LK_HELD` to `LK_FREE`): any port writes zero to it.
- In every other case the state is kept.

Top module: `hsl_bank`

## Requirements
- R1: A read of a free semaphore returns 0 and leaves that semaphore held.
- R2: A read of a held semaphore returns 1, and the semaphore stays held.
- R3: A write of zero to a semaphore register frees it. A write of any non-zero value has no effect.
- R4: When two or more ports read the same free semaphore in one cycle, only the lowest-numbered port gets 0. The others get 1. Reads of different free semaphores in one cycle all succeed.
- R5: The status word at byte offset 0x014 reads as NUM_LOCKS/32 in bits 27:24, with all other bits 0. For example, it reads 0x0200_0000 for 64 semaphores. Writes to it have no effect.
- R6: Semaphore i sits at byte offset 0x800 + 4*i. Reads of any other offset return 0 and change no semaphore. This includes unaligned offsets and offsets past the last semaphore.
- R7: After reset every semaphore is free.
- R8: When a held semaphore is read and written with zero in the same cycle, the read returns 1 and the semaphore ends free. When a free semaphore is read and written with zero in the same cycle, the read returns 0 and the semaphore ends held.
- R9: Read data appears on the clock edge after the read strobe. It is 0 in any cycle that follows a cycle with no read on that port. If a port asserts both strobes together, the access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | NPORTS x ADDR_W | Byte address for each port |
| bus_rd | input | NPORTS | Read strobe for each port |
| bus_wr | input | NPORTS | Write strobe for each port |
| bus_wdata | input | NPORTS x 32 | Write data for each port |
| bus_rdata | output | NPORTS x 32 | Registered read data for each port |

## Verification
The test-and-set is exercised with several patterns:
- Single-port reads of fresh and already-held semaphores separate the ACQUIRE path from the hold path.
- Simultaneous reads of one semaphore from two ports show whether the fixed priority gives a single winner. Simultaneous reads of two different semaphores show that the priority does not block unrelated accesses.
- A read and a zero-write landing in the same cycle, once on a held semaphore and once on a free one, pin down which of the two accesses takes effect.
- Two requesters loop with back-off on one semaphore while the bench counts how many hold it at once. This catches any double grant under contention.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    localparam int LOCK_BASE  = 'h800;
    localparam int STATUS_OFS = 'h014;
    localparam int COUNT_LSB  = 24;

    function automatic logic [31:0] status_word(input int n_locks);
        logic [31:0] w;
        w = '0;
        w[COUNT_LSB +: 4] = 4'(n_locks / 32);
        return w;
    endfunction

endpackage

// File: rtl/hsl_port_decode.sv
module hsl_port_decode
    import hsl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LOCKS = 64,
    localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_lock,
    output logic              is_status,
    output logic [IDX_W-1:0]  idx
);
    localparam int WIN_END = LOCK_BASE + 4 * NUM_LOCKS;

    logic [31:0] a32;
    logic [31:0] ofs;

    always_comb begin
        a32       = 32'(addr);
        ofs       = a32 - 32'(LOCK_BASE);
        is_lock   = (a32 >= 32'(LOCK_BASE)) && (a32 < 32'(WIN_END)) && (addr[1:0] == 2'b00);
        is_status = (a32 == 32'(STATUS_OFS));
        idx       = IDX_W'(ofs >> 2);
    end

endmodule

// File: rtl/hsl_lock_cell.sv
module hsl_lock_cell
    import hsl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic rel,
    output logic held
);
    lock_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= LK_FREE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            LK_FREE: if (take) st_nx = LK_HELD;   // ACQUIRE
            LK_HELD: if (rel)  st_nx = LK_FREE;   // RELEASE
            default: st_nx = LK_FREE;
        endcase
    end

    always_comb held = (st == LK_HELD);

endmodule

// File: rtl/hsl_port_resp.sv
module hsl_port_resp (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd,
    input  logic        is_lock,
    input  logic        is_status,
    input  logic        granted,
    input  logic [31:0] status_word,
    output logic [31:0] rdata
);
    logic [31:0] rdata_nx;

    always_comb begin
        rdata_nx = '0;
        if (rd) begin
            if (is_lock)        rdata_nx = granted ? 32'd0 : 32'd1;
            else if (is_status) rdata_nx = status_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rdata_nx;
    end

endmodule

// File: rtl/hsl_bank.sv
module hsl_bank
    import hsl_pkg::*;
#(
    parameter int NUM_LOCKS = 64,
    parameter int NPORTS    = 2,
    parameter int ADDR_W    = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPORTS-1:0][ADDR_W-1:0]  bus_addr,
    input  logic [NPORTS-1:0]              bus_rd,
    input  logic [NPORTS-1:0]              bus_wr,
    input  logic [NPORTS-1:0][31:0]        bus_wdata,
    output logic [NPORTS-1:0][31:0]        bus_rdata
);
    localparam int          IDX_W  = $clog2(NUM_LOCKS);
    localparam logic [31:0] STATUS = status_word(NUM_LOCKS);

    logic [NPORTS-1:0]    is_lock;
    logic [NPORTS-1:0]    is_status;
    logic [IDX_W-1:0]     idx [NPORTS];
    logic [NPORTS-1:0]    granted;
    logic [NUM_LOCKS-1:0] take_v;
    logic [NUM_LOCKS-1:0] rel_v;
    logic [NUM_LOCKS-1:0] lock_held;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        hsl_port_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) dec_i (
            .addr      (bus_addr[p]),
            .is_lock   (is_lock[p]),
            .is_status (is_status[p]),
            .idx       (idx[p])
        );

        hsl_port_resp resp_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .rd          (bus_rd[p]),
            .is_lock     (is_lock[p]),
            .is_status   (is_status[p]),
            .granted     (granted[p]),
            .status_word (STATUS),
            .rdata       (bus_rdata[p])
        );
    end

    // Per-lock requests gathered from all ports; a read outranks a write on the same port.
    always_comb begin
        take_v = '0;
        rel_v  = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (bus_rd[p] && is_lock[p])
                take_v[idx[p]] = 1'b1;
            if (bus_wr[p] && !bus_rd[p] && is_lock[p] && (bus_wdata[p] == 32'd0))
                rel_v[idx[p]] = 1'b1;
        end
    end

    // Fixed priority: a lower port reading the same lock in this cycle wins.
    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            granted[p] = !lock_held[idx[p]];
            for (int q = 0; q < p; q++) begin
                if (bus_rd[q] && is_lock[q] && (idx[q] == idx[p]))
                    granted[p] = 1'b0;
            end
        end
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        hsl_lock_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (take_v[i]),
            .rel   (rel_v[i]),
            .held  (lock_held[i])
        );
    end

endmodule

// File: rtl/hsl_bank_chk.sv
module hsl_bank_chk #(
    parameter int NUM_LOCKS = 64,
    parameter int NPORTS    = 2,
    parameter int ADDR_W    = 12
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NPORTS-1:0][ADDR_W-1:0] bus_addr,
    input logic [NPORTS-1:0]             bus_rd,
    input logic [NPORTS-1:0]             bus_wr,
    input logic [NPORTS-1:0][31:0]       bus_rdata,
    input logic [NUM_LOCKS-1:0]          held
);
    localparam int          IDX_W = $clog2(NUM_LOCKS);
    localparam logic [31:0] EXP_STATUS = 32'(NUM_LOCKS / 32) << 24;

    logic [NPORTS-1:0] c_lock;
    logic [NPORTS-1:0] c_stat;
    logic [IDX_W-1:0]  c_idx [NPORTS];

    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            c_lock[p] = (bus_addr[p][1:0] == 2'b00) &&
                        (32'(bus_addr[p]) >= 32'h800) &&
                        (32'(bus_addr[p]) <  32'h800 + 32'(4 * NUM_LOCKS));
            c_stat[p] = (32'(bus_addr[p]) == 32'h14);
            c_idx[p]  = IDX_W'((32'(bus_addr[p]) - 32'h800) >> 2);
        end
    end

    p_reset_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (held == '0));

    p_take_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd[0] && c_lock[0] && !held[c_idx[0]]) |=>
            ((bus_rdata[0] == 32'd0) && held[$past(c_idx[0])]));

    p_held_reads_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd[0] && c_lock[0] && held[c_idx[0]]) |=> (bus_rdata[0] == 32'd1));

    p_status_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd[0] && c_stat[0]) |=> (bus_rdata[0] == EXP_STATUS));

    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd[0] && !c_lock[0] && !c_stat[0]) |=> (bus_rdata[0] == 32'd0));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd[0] |=> (bus_rdata[0] == 32'd0));

    if (NPORTS > 1) begin : g_race
        p_single_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd[0] && bus_rd[1] && c_lock[0] && c_lock[1] && (c_idx[0] == c_idx[1]))
                |=> (bus_rdata[1] == 32'd1));

        p_held_read_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd[0] && c_lock[0] && held[c_idx[0]] && bus_wr[1] && !bus_rd[1])
                |=> (bus_rdata[0] == 32'd1));
    end

endmodule

bind hsl_bank hsl_bank_chk #(
    .NUM_LOCKS (NUM_LOCKS),
    .NPORTS    (NPORTS),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .held      (lock_held)
);

// File: tb/hsl_bank_tb.sv
module hsl_bank_tb_top;
    localparam int NUM_LOCKS = 64;
    localparam int NPORTS    = 2;
    localparam int ADDR_W    = 12;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic [NPORTS-1:0][ADDR_W-1:0] bus_addr = '0;
    logic [NPORTS-1:0]             bus_rd = '0;
    logic [NPORTS-1:0]             bus_wr = '0;
    logic [NPORTS-1:0][31:0]       bus_wdata = '0;
    logic [NPORTS-1:0][31:0]       bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int occ     = 0;
    int grabs   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    hsl_bank #(.NUM_LOCKS(NUM_LOCKS), .NPORTS(NPORTS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [ADDR_W-1:0] lk(input int i);
        return ADDR_W'(32'h800 + 4 * i);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One access on port p; returns the read data registered at the following edge.
    task automatic acc(input int p, input bit wr, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        bus_addr[p]  = a;
        bus_rd[p]    = !wr;
        bus_wr[p]    = wr;
        bus_wdata[p] = d;
        @(negedge clk);
        bus_rd[p] = 1'b0;
        bus_wr[p] = 1'b0;
        q = bus_rdata[p];
    endtask

    task automatic t_reset;
        logic [31:0] q;
        check("R9 rdata0 after reset", bus_rdata[0], 32'd0);
        check("R9 rdata1 after reset", bus_rdata[1], 32'd0);
        acc(0, 0, lk(NUM_LOCKS - 1), 0, q); check("R7 last lock free after reset", q, 32'd0);
        acc(1, 0, lk(5), 0, q);             check("R7 lock5 free after reset", q, 32'd0);
        acc(0, 1, lk(NUM_LOCKS - 1), 0, q);
        acc(1, 1, lk(5), 0, q);
    endtask

    task automatic t_take_hold;
        logic [31:0] q;
        acc(0, 0, lk(3), 0, q); check("R1 first read takes", q, 32'd0);
        acc(0, 0, lk(3), 0, q); check("R2 second read held", q, 32'd1);
        acc(1, 0, lk(3), 0, q); check("R2 other port sees held", q, 32'd1);
    endtask

    task automatic t_release;
        logic [31:0] q;
        acc(0, 1, lk(3), 32'hFFFF, q);
        acc(1, 0, lk(3), 0, q); check("R3 nonzero write ignored", q, 32'd1);
        acc(0, 1, lk(3), 0, q);
        acc(1, 0, lk(3), 0, q); check("R3 zero write frees", q, 32'd0);
        acc(1, 1, lk(3), 0, q);
    endtask

    task automatic t_race;
        logic [31:0] q0, q1;
        fork
            acc(0, 0, lk(10), 0, q0);
            acc(1, 0, lk(10), 0, q1);
        join
        check("R4 port0 wins race", q0, 32'd0);
        check("R4 port1 loses race", q1, 32'd1);
        acc(0, 1, lk(10), 0, q0);
        fork
            acc(0, 0, lk(11), 0, q0);
            acc(1, 0, lk(12), 0, q1);
        join
        check("R4 distinct lock port0", q0, 32'd0);
        check("R4 distinct lock port1", q1, 32'd0);
        acc(0, 1, lk(11), 0, q0);
        acc(1, 1, lk(12), 0, q1);
    endtask

    task automatic t_status;
        logic [31:0] q;
        logic [31:0] exp;
        exp = 32'(NUM_LOCKS / 32) << 24;
        acc(0, 0, ADDR_W'(32'h14), 0, q); check("R5 status word", q, exp);
        acc(1, 1, ADDR_W'(32'h14), 32'hFFFF_FFFF, q);
        acc(1, 0, ADDR_W'(32'h14), 0, q); check("R5 status after write", q, exp);
    endtask

    task automatic t_unmapped;
        logic [31:0] q;
        acc(0, 0, lk(NUM_LOCKS), 0, q);   check("R6 past last lock reads 0", q, 32'd0);
        acc(0, 0, ADDR_W'(32'h802), 0, q); check("R6 unaligned reads 0", q, 32'd0);
        acc(0, 0, ADDR_W'(32'h0), 0, q);   check("R6 offset 0 reads 0", q, 32'd0);
        acc(1, 0, lk(0), 0, q);            check("R6 lock0 untouched", q, 32'd0);
        acc(1, 1, lk(0), 0, q);
    endtask

    task automatic t_same_cycle;
        logic [31:0] q0, q1;
        acc(0, 0, lk(7), 0, q0);
        fork
            acc(0, 0, lk(7), 0, q0);
            acc(1, 1, lk(7), 0, q1);
        join
        check("R8 read of held during release", q0, 32'd1);
        acc(0, 0, lk(7), 0, q0); check("R8 lock freed by release", q0, 32'd0);
        acc(0, 1, lk(7), 0, q0);
        fork
            acc(0, 0, lk(8), 0, q0);
            acc(1, 1, lk(8), 0, q1);
        join
        check("R8 read of free during release", q0, 32'd0);
        acc(1, 0, lk(8), 0, q1); check("R8 free lock ends held", q1, 32'd1);
        acc(1, 1, lk(8), 0, q1);
    endtask

    task automatic t_latency;
        logic [31:0] q;
        acc(0, 0, lk(9), 0, q);
        @(negedge clk);
        check("R9 rdata cleared after idle cycle", bus_rdata[0], 32'd0);
        acc(0, 1, lk(9), 0, q);
        check("R9 write returns 0", q, 32'd0);
    endtask

    task automatic requester(input int p, input int rounds);
        logic [31:0] q;
        int got;
        got = 0;
        while (got < rounds) begin
            acc(p, 0, lk(20), 0, q);
            if (q == 32'd0) begin
                occ++;
                check("R4 exclusive hold under contention", 32'(occ), 32'd1);
                grabs++;
                got++;
                repeat (3) @(negedge clk);
                occ--;
                acc(p, 1, lk(20), 0, q);
            end else begin
                repeat (5) @(negedge clk);
            end
        end
    endtask

    task automatic t_contend;
        fork
            requester(0, 4);
            requester(1, 4);
        join
        check("R1 all contended grabs done", 32'(grabs), 32'd8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_take_hold();
        t_release();
        t_race();
        t_status();
        t_unmapped();
        t_same_cycle();
        t_latency();
        t_contend();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule